// File: doc/BRIEF.md
# Variable-Length SPI Master

This block is a full-duplex SPI master for mode 0 (clock idles low, data sampled on the rising edge, data changed on the falling edge). One start strobe runs a transfer of 1 to 32 bits. The transmit word goes out on MOSI, most significant bit first. The same number of bits is captured from MISO into a right-aligned receive word. The serial clock runs at the system clock divided by 2*DIV, and DIV is a parameter.

Several active-low slave-select outputs are driven from a select mask. Lines are granted strictly from line 0 upward: a mask bit only takes effect when every lower bit is also set. In automatic mode the select lines release when a transfer ends. In manual mode they stay asserted across any number of transfers until the hold input goes low while the block is idle. This suits command, address and data phases sent to a memory as separate transfers. The end of each transfer is signalled in three ways: a one-cycle done pulse, a sticky completion flag that can be polled, and an interrupt pulse when interrupts are enabled.

Top module: `spi_var_master`

## Requirements
- R1: While reset is held and after it is released, all select outputs are high, SCLK and MOSI are low, and busy, done, the completion flag and the interrupt are low.
- R2: The length field holds n-1, where n is 1 to 32. A transfer produces exactly n rising SCLK edges, and busy stays high for exactly 2*DIV*n cycles.
- R3: MOSI sends bits n-1 down to 0 of the transmit word, most significant first. MOSI holds steady during every cycle in which SCLK is high.
- R4: The receive word holds the n bits captured from MISO on the rising edges. The first captured bit lands in bit n-1 and the last in bit 0, and bits 31 down to n read zero.
- R5: SCLK is low whenever busy is low.
- R6: Selects are active low. The lines asserted for a transfer are the longest run of set mask bits starting from bit 0, so the asserted set is always a contiguous group beginning at line 0.
- R7: In automatic mode (hold input low at start), the select lines return high in the same cycle that done pulses.
- R8: In manual mode (hold input high at start), the select lines stay low after done and through the following transfers. Once the hold input is low while idle, they return high on the next clock edge.
- R9: A start strobe while busy is ignored. The running transfer keeps its data and its length.
- R10: Busy rises on the cycle after an accepted start. Done is a one-cycle pulse in the cycle busy falls.
- R11: The interrupt pulses together with done only if interrupts were enabled at the start. The completion flag sets with done and clears on the next accepted start.

Top module ports, in order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe; taken only when idle |
| tx_word_i | input | 32 | Transmit word; the low n bits are sent |
| len_m1_i | input | 5 | Transfer length minus one |
| sel_mask_i | input | NSEL | Requested select lines, bit i for line i |
| manual_i | input | 1 | Select hold: high for manual mode, low for automatic mode |
| irq_en_i | input | 1 | Interrupt enable, latched at start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| stat_done_o | output | 1 | Sticky completion flag for polling |
| irq_o | output | 1 | Interrupt pulse |
| rx_word_o | output | 32 | Right-aligned received word |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NSEL | Active-low slave selects |

## Verification
A start presented before edge E0 shows busy and the select lines in the first cycle after E0. Done, the interrupt, the flag and the auto-mode select release all appear in the cycle after edge E0 plus 2*DIV*n. A manual release appears one cycle after the hold input is seen low. The bench drives every input on the falling clock edge and counts falling edges while busy is high. It then samples done, the receive word, the selects and the slave-side capture on the exact falling edge where busy is first seen low. A slave model that counts rising SCLK edges provides the MISO data and collects the MOSI bits, so the shifted data and the number of edges are checked at the serial pins as well as at the word ports.

// File: rtl/spi_var_pkg.sv
package spi_var_pkg;
  localparam int unsigned SPI_WORD_W = 32;
  localparam int unsigned SPI_LEN_W  = $clog2(SPI_WORD_W);

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/spi_var_rst_sync.sv
module spi_var_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_s = sync_q[1];
endmodule

// File: rtl/spi_var_clkgen.sv
module spi_var_clkgen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          half_end;

  assign half_end = run_i && (cnt_q == CNT_TOP);

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run_i) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (half_end) begin
      cnt_d  = '0;
      sclk_d = !sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = half_end && !sclk_q;
  assign fall_o = half_end && sclk_q;
endmodule

// File: rtl/spi_var_shift.sv
module spi_var_shift
  import spi_var_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [SPI_WORD_W-1:0] tx_word_i,
  input  logic [SPI_LEN_W-1:0]  len_m1_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  miso_i,
  output logic                  tx_msb_o,
  output logic [SPI_WORD_W-1:0] rx_word_o,
  output logic                  last_o
);
  localparam logic [SPI_LEN_W-1:0] TOP_IDX = SPI_LEN_W'(SPI_WORD_W - 1);

  logic [SPI_WORD_W-1:0] tx_q, tx_d;
  logic [SPI_WORD_W-1:0] rx_q, rx_d;
  logic [SPI_LEN_W-1:0]  left_q, left_d;

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    left_d = left_q;
    if (load_i) begin
      // left-align the n live bits so the first one sits in the top bit
      tx_d   = tx_word_i << (TOP_IDX - len_m1_i);
      rx_d   = '0;
      left_d = len_m1_i;
    end else begin
      if (rise_i) rx_d = {rx_q[SPI_WORD_W-2:0], miso_i};
      if (fall_i) begin
        tx_d = {tx_q[SPI_WORD_W-2:0], 1'b0};
        if (left_q != '0) left_d = left_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      left_q <= left_d;
    end
  end

  assign tx_msb_o  = tx_q[SPI_WORD_W-1];
  assign rx_word_o = rx_q;
  assign last_o    = fall_i && (left_q == '0);
endmodule

// File: rtl/spi_var_sel.sv
module spi_var_sel #(
  parameter int unsigned NSEL = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept_i,
  input  logic [NSEL-1:0] mask_i,
  input  logic            manual_i,
  input  logic            end_i,
  input  logic            busy_i,
  output logic [NSEL-1:0] ss_n_o
);
  logic [NSEL-1:0] grant;
  logic [NSEL-1:0] act_q, act_d;
  logic            hold_q, hold_d;

  // a line is granted only when it and every lower line are requested
  assign grant[0] = mask_i[0];
  for (genvar i = 1; i < NSEL; i++) begin : g_prefix
    assign grant[i] = grant[i-1] & mask_i[i];
  end

  always_comb begin
    act_d  = act_q;
    hold_d = hold_q;
    if (accept_i) begin
      act_d  = grant;
      hold_d = manual_i;
    end else if (end_i && !hold_q) begin
      act_d = '0;
    end else if (!busy_i && !manual_i) begin
      act_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      hold_q <= hold_d;
    end
  end

  assign ss_n_o = ~act_q;
endmodule

// File: rtl/spi_var_master.sv
module spi_var_master
  import spi_var_pkg::*;
#(
  parameter int unsigned NSEL = 4,
  parameter int unsigned DIV  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [SPI_WORD_W-1:0] tx_word_i,
  input  logic [SPI_LEN_W-1:0]  len_m1_i,
  input  logic [NSEL-1:0]       sel_mask_i,
  input  logic                  manual_i,
  input  logic                  irq_en_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  stat_done_o,
  output logic                  irq_o,
  output logic [SPI_WORD_W-1:0] rx_word_o,
  output logic                  sclk_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic [NSEL-1:0]       ss_n_o
);
  logic        rst_n_s;
  xfer_state_e st_q, st_d;
  logic        done_q, done_d;
  logic        stat_q, stat_d;
  logic        ien_q, ien_d;
  logic        busy, accept, rise, fall, last_fall, xfer_end, tx_msb;

  spi_var_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  assign busy     = (st_q == ST_SHIFT);
  assign accept   = start_i && !busy;
  assign xfer_end = busy && last_fall;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    stat_d = stat_q;
    ien_d  = ien_q;
    if (accept) begin
      st_d   = ST_SHIFT;
      stat_d = 1'b0;
      ien_d  = irq_en_i;
    end else if (xfer_end) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      stat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      stat_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      stat_q <= stat_d;
      ien_q  <= ien_d;
    end
  end

  spi_var_clkgen #(.DIV(DIV)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run_i  (busy),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  spi_var_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .load_i    (accept),
    .tx_word_i (tx_word_i),
    .len_m1_i  (len_m1_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .miso_i    (miso_i),
    .tx_msb_o  (tx_msb),
    .rx_word_o (rx_word_o),
    .last_o    (last_fall)
  );

  spi_var_sel #(.NSEL(NSEL)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .accept_i (accept),
    .mask_i   (sel_mask_i),
    .manual_i (manual_i),
    .end_i    (xfer_end),
    .busy_i   (busy),
    .ss_n_o   (ss_n_o)
  );

  assign busy_o      = busy;
  assign done_o      = done_q;
  assign stat_done_o = stat_q;
  assign irq_o       = done_q & ien_q;
  assign mosi_o      = busy & tx_msb;
endmodule

// File: rtl/spi_var_master_chk.sv
module spi_var_master_chk #(
  parameter int unsigned NSEL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            irq_o,
  input logic            sclk_o,
  input logic            mosi_o,
  input logic [NSEL-1:0] ss_n_o
);
  logic [NSEL-1:0] act, act_inc;

  always_comb begin
    act     = ~ss_n_o;
    act_inc = act + 1'b1;
  end

  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(mosi_o));

  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r11_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> done_o);

  a_r6_prefix_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (act & act_inc) == '0);
endmodule

bind spi_var_master spi_var_master_chk #(.NSEL(NSEL)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .irq_o   (irq_o),
  .sclk_o  (sclk_o),
  .mosi_o  (mosi_o),
  .ss_n_o  (ss_n_o)
);

// File: tb/spi_var_master_tb.sv
module spi_var_master_tb_top;
  localparam int NSEL = 4;
  localparam int DIV  = 2;
  localparam int NV   = 6;

  localparam logic [31:0] V_TX [0:NV-1] = '{32'h0000_00A5, 32'h0312_3456, 32'h0000_0001,
                                            32'hFFFF_1ABC, 32'h0055_AA33, 32'hFFFF_FFE0};
  localparam logic [31:0] V_SL [0:NV-1] = '{32'h0000_003C, 32'hDEAD_BEEF, 32'h0000_0001,
                                            32'h0000_0F0F, 32'h00C3_3C81, 32'h0000_001F};
  localparam int          V_N  [0:NV-1] = '{8, 32, 1, 13, 24, 5};
  localparam logic [3:0]  V_MK [0:NV-1] = '{4'b0001, 4'b0011, 4'b0001, 4'b0111, 4'b1111, 4'b0101};

  logic clk, rst_n, start_i, manual_i, irq_en_i, miso_i;
  logic [31:0] tx_word_i;
  logic [4:0]  len_m1_i;
  logic [NSEL-1:0] sel_mask_i, ss_n_o;
  logic busy_o, done_o, stat_done_o, irq_o, sclk_o, mosi_o;
  logic [31:0] rx_word_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // slave model state
  int          rises = 0;
  logic [31:0] sl_rx = '0;
  logic [31:0] sl_word = '0;
  int          sl_n = 1;
  int          base = 0;

  spi_var_master #(.NSEL(NSEL), .DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_word_i(tx_word_i),
    .len_m1_i(len_m1_i), .sel_mask_i(sel_mask_i), .manual_i(manual_i),
    .irq_en_i(irq_en_i), .busy_o(busy_o), .done_o(done_o),
    .stat_done_o(stat_done_o), .irq_o(irq_o), .rx_word_o(rx_word_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .ss_n_o(ss_n_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge sclk_o) begin
    sl_rx <= {sl_rx[30:0], mosi_o};
    rises <= rises + 1;
  end

  always_comb begin
    int idx;
    idx = sl_n - 1 - (rises - base);
    miso_i = (idx >= 0 && idx < 32) ? sl_word[idx] : 1'b0;
  end

  function automatic logic [31:0] low_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [NSEL-1:0] granted(input logic [NSEL-1:0] m);
    logic [NSEL-1:0] g;
    bit run;
    g = '0; run = 1'b1;
    for (int i = 0; i < NSEL; i++) begin
      run = run & m[i];
      g[i] = run;
    end
    return g;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // runs one transfer; returns busy cycle count, sampled at the negedge where busy drops
  task automatic run_xfer(input logic [31:0] tx, input int n, input logic [31:0] sl,
                          input logic [NSEL-1:0] mask, input logic man, input logic ien,
                          input bit poke, output int cyc, output logic [NSEL-1:0] ss_mid);
    @(negedge clk);
    tx_word_i = tx; len_m1_i = 5'(n - 1); sel_mask_i = mask;
    manual_i = man; irq_en_i = ien;
    sl_word = sl; sl_n = n; base = rises;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    ss_mid = ss_n_o;
    while (busy_o && cyc < 5000) begin
      cyc++;
      if (poke && cyc == 3) begin
        start_i = 1'b1; tx_word_i = ~tx; len_m1_i = 5'd0;
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic check_result(input string tag, input logic [31:0] tx, input int n,
                              input logic [31:0] sl, input logic [NSEL-1:0] mask,
                              input logic ien, input int cyc, input logic [NSEL-1:0] ss_mid);
    chk(cyc == 2*DIV*n, "R2", {tag, " busy cycles"}, 32'(cyc), 32'(2*DIV*n));
    chk((rises - base) == n, "R2", {tag, " sclk rises"}, 32'(rises - base), 32'(n));
    chk(done_o == 1'b1 && busy_o == 1'b0, "R10", {tag, " done with busy low"},
        {30'd0, done_o, busy_o}, 32'h2);
    chk((sl_rx & low_mask(n)) == (tx & low_mask(n)), "R3", {tag, " slave got MSB-first data"},
        sl_rx & low_mask(n), tx & low_mask(n));
    chk(rx_word_o == (sl & low_mask(n)), "R4", {tag, " right-aligned rx"},
        rx_word_o, sl & low_mask(n));
    chk(ss_mid == ~granted(mask), "R6", {tag, " selects during transfer"},
        32'(ss_mid), 32'(~granted(mask)));
    chk(irq_o == ien, "R11", {tag, " irq pulse"}, 32'(irq_o), 32'(ien));
    chk(stat_done_o == 1'b1, "R11", {tag, " completion flag"}, 32'(stat_done_o), 32'h1);
  endtask

  initial begin
    int cyc;
    logic [NSEL-1:0] ssm;
    rst_n = 1'b0; start_i = 1'b0; tx_word_i = '0; len_m1_i = '0;
    sel_mask_i = '0; manual_i = 1'b0; irq_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(ss_n_o == '1 && !sclk_o && !mosi_o && !busy_o && !done_o && !irq_o && !stat_done_o,
        "R1", "outputs in reset", {25'd0, ss_n_o, sclk_o, mosi_o, busy_o},
        {25'd0, 4'hF, 3'b000});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ss_n_o == '1 && !sclk_o && !mosi_o && !busy_o && !done_o && !irq_o && !stat_done_o,
        "R1", "outputs after release", {25'd0, ss_n_o, sclk_o, mosi_o, busy_o},
        {25'd0, 4'hF, 3'b000});

    // table of vectors, automatic mode
    for (int v = 0; v < NV; v++) begin
      run_xfer(V_TX[v], V_N[v], V_SL[v], V_MK[v], 1'b0, 1'(v % 2), 1'b0, cyc, ssm);
      check_result($sformatf("vec%0d", v), V_TX[v], V_N[v], V_SL[v], V_MK[v],
                   1'(v % 2), cyc, ssm);
      chk(ss_n_o == '1, "R7", $sformatf("vec%0d auto release with done", v),
          32'(ss_n_o), 32'hF);
      chk(!sclk_o, "R5", $sformatf("vec%0d sclk idle low", v), 32'(sclk_o), 32'h0);
    end

    // flag clears on the next accepted start
    @(negedge clk);
    tx_word_i = 32'h1; len_m1_i = 5'd3; sel_mask_i = 4'b0001; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(stat_done_o == 1'b0 && busy_o, "R11", "flag cleared by start",
        {30'd0, stat_done_o, busy_o}, 32'h1);
    while (busy_o) @(negedge clk);

    // mask 0110 grants nothing
    run_xfer(32'h5, 3, 32'h2, 4'b0110, 1'b0, 1'b0, 1'b0, cyc, ssm);
    chk(ssm == '1, "R6", "non-prefix mask grants no line", 32'(ssm), 32'hF);
    chk(rx_word_o == 32'h2, "R4", "rx with no line granted", rx_word_o, 32'h2);

    // start while busy is ignored
    run_xfer(32'h0000_9C3A, 16, 32'h0000_4E21, 4'b0001, 1'b0, 1'b0, 1'b1, cyc, ssm);
    chk(cyc == 2*DIV*16, "R9", "length kept despite start while busy", 32'(cyc), 32'(2*DIV*16));
    chk((sl_rx & 32'hFFFF) == 32'h9C3A, "R9", "data kept despite start while busy",
        sl_rx & 32'hFFFF, 32'h9C3A);
    repeat (2) @(negedge clk);
    chk(!busy_o, "R9", "no second transfer from ignored start", 32'(busy_o), 32'h0);

    // manual mode: select held over two transfers, then released
    run_xfer(32'h03, 8, 32'h0, 4'b0011, 1'b1, 1'b0, 1'b0, cyc, ssm);
    chk(ss_n_o == 4'b1100, "R8", "manual hold at done", 32'(ss_n_o), 32'hC);
    repeat (3) @(negedge clk);
    chk(ss_n_o == 4'b1100, "R8", "manual hold while idle", 32'(ss_n_o), 32'hC);
    run_xfer(32'h00AB_CDEF, 24, 32'h0012_3456, 4'b0011, 1'b1, 1'b1, 1'b0, cyc, ssm);
    chk(ssm == 4'b1100, "R8", "manual select in second transfer", 32'(ssm), 32'hC);
    chk(rx_word_o == 32'h0012_3456, "R4", "manual second transfer rx", rx_word_o, 32'h0012_3456);
    chk(ss_n_o == 4'b1100, "R8", "manual hold after second done", 32'(ss_n_o), 32'hC);
    manual_i = 1'b0;
    @(negedge clk);
    chk(ss_n_o == 4'b1111, "R8", "release after hold dropped", 32'(ss_n_o), 32'hF);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule